// File: doc/BRIEF.md
# Word-packing UART receiver with idle-timeout transfer end

This block is the receive half of a serial port. It samples the RX line with an oversampling tick and decodes 8-bit characters framed by one start bit and one stop bit, least significant bit first. It packs the characters into 32-bit words and pushes each word into a small receive FIFO. The first character of a word occupies bits 7:0 and the fourth occupies bits 31:24.

Software starts a receive transfer by writing the transfer-length register. The transfer ends in one of two ways. The first is when the line stays quiet for a programmed number of character times after at least one character has arrived; this is the stale event. The second is when the programmed length is reached. When a transfer ends, any partly filled word is pushed with zero upper bytes, and the character count is latched into a snapshot register. Software uses the snapshot to know how many bytes of the last word are valid. Overrun and framing errors are held in sticky status bits. A level interrupt compares the FIFO word count against a watermark.

The register map is as follows:

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | data | read, pops | FIFO head word |
| 1 | status | read | bit0 FIFO not empty, bit1 FIFO full, bit2 overrun, bit3 frame error, bit4 stale flag, bit5 armed |
| 2 | command | write | bit0 reset receiver, bit1 reset error status, bit2 clear stale flag |
| 3 | transfer length | read/write | a write arms the receiver |
| 4 | stale timeout | read/write | in character times |
| 5 | watermark | read/write | |
| 6 | snapshot | read | character count latched at the end of a transfer |
| 7 | level | read | FIFO word count |

Top module: `uart_wordpack_rx`

## Requirements
- R1: Characters are 8N1 frames, LSB first, each bit lasting OVS ticks of `os_tick`. They are packed into 32-bit words with the first character in bits 7:0, and the word read from address 0 holds them in that order.
- R2: A character is stored only while the receiver is armed. A write to address 3 arms the receiver and clears the character count. A character that arrives while the receiver is not armed leaves the FIFO level at address 7 unchanged.
- R3: The stale event is raised once at least one character has been stored and the line has then stayed idle for the number of character times in the stale timeout register (address 4, reset value 15, one character time being 10 bit times). The event sets status bit4 and `irq_stale`, and it disarms the receiver.
- R4: When a transfer ends, the snapshot register (address 6) holds the number of characters stored in that transfer.
- R5: When a transfer ends with a partly filled word, that word is pushed to the FIFO with its unused upper bytes set to zero.
- R6: When the transfer length is between 1 and 4*DEPTH, the transfer ends right after that many characters, without waiting for the timeout. The snapshot is latched, the receiver disarms, and no stale event is raised. A larger length ends the transfer only on the stale event.
- R7: After a stale event, no further characters are stored and no new stale event is raised until software clears the stale flag (command bit2) and re-arms the receiver.
- R8: A character that arrives while the FIFO is full is discarded and sets the sticky overrun bit (status bit2). Command bit1 clears the overrun bit.
- R9: A character whose sampled stop bit is low is still stored, and it sets the sticky frame-error bit (status bit3). Command bit1 clears the frame-error bit.
- R10: `irq_rxlev` is high exactly when the FIFO word count (address 7) is greater than the watermark (address 5).
- R11: The reset-receiver command (command bit0) empties the FIFO, discards the partial word, clears the count and the snapshot, and disarms the receiver.
- R12: A read of address 0 with `reg_re` high removes the head word when the FIFO is not empty. Status bit0 shows that the FIFO is not empty and bit1 shows that it is full, and the level never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OVS per bit time |
| rx_in | input | 1 | Serial receive line, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops at address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq_rxlev | output | 1 | FIFO level above watermark |
| irq_stale | output | 1 | Stale event pending |

## Verification
The bench builds the block with OVS=4 and DEPTH=4, and it pulses the tick every other clock. One bit then lasts 8 clocks and one character time lasts 80 clocks. With these values, the default 15-character timeout can be measured against a window of about 100 cycles around its expected expiry. Because DEPTH=4 gives a FIFO of 16 characters, the full flag and the overrun discard are reached with a 17-character burst. The length-based end of a transfer can be compared with the 4*DEPTH capacity limit using small numbers.

// File: rtl/uart_wordpack_rx.sv
module uart_wordpack_rx #(
  parameter int OVS   = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rx_in,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_rxlev,
  output logic        irq_stale
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW  = $clog2(DEPTH + 1);
  localparam int CAP = 4 * DEPTH;
  localparam int OW  = $clog2(OVS);
  localparam int CHT = 10 * OVS;
  localparam int TW  = $clog2(CHT);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [1:0]    rx_sync;
  logic          rx_s;
  st_t           state;
  logic [OW-1:0] tcnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          char_done, char_ferr;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] level, wmark;
  logic [31:0]   pword, merged, push_data;
  logic [1:0]    bidx;
  logic [CW-1:0] char_cnt, xlen, snap;
  logic [7:0]    stale_to, ichar;
  logic [TW-1:0] ctick;
  logic          armed, stale_flag, overrun, ferr;

  assign rx_s = rx_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync   <= 2'b11;
      state     <= S_IDLE;
      tcnt      <= '0;
      bitn      <= '0;
      shreg     <= '0;
      char_done <= 1'b0;
      char_ferr <= 1'b0;
    end else begin
      rx_sync   <= {rx_sync[0], rx_in};
      char_done <= 1'b0;
      if (state == S_IDLE) begin
        if (!rx_s) begin
          state <= S_START;
          tcnt  <= '0;
        end
      end else if (os_tick) begin
        case (state)
          S_START:
            if (tcnt == OW'(OVS/2 - 1)) begin
              tcnt  <= '0;
              bitn  <= '0;
              state <= rx_s ? S_IDLE : S_DATA;
            end else tcnt <= tcnt + 1'b1;
          S_DATA:
            if (tcnt == OW'(OVS - 1)) begin
              tcnt  <= '0;
              shreg <= {rx_s, shreg[7:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == 3'd7) state <= S_STOP;
            end else tcnt <= tcnt + 1'b1;
          S_STOP:
            if (tcnt == OW'(OVS - 1)) begin
              state     <= S_IDLE;
              char_done <= 1'b1;
              char_ferr <= ~rx_s;
            end else tcnt <= tcnt + 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  logic wr_len, cmd, rst_rx, rst_err, clr_stale, pop, full;
  logic take, ovr_char, len_hit, char_push, counting, stale_ev, flush_push, flush_ovr, push;

  assign wr_len    = reg_we && reg_addr == 3'd3;
  assign cmd       = reg_we && reg_addr == 3'd2;
  assign rst_rx    = cmd && reg_wdata[0];
  assign rst_err   = cmd && reg_wdata[1];
  assign clr_stale = cmd && reg_wdata[2];
  assign full      = level == LW'(DEPTH);
  assign pop       = reg_re && reg_addr == 3'd0 && level != '0;

  assign take      = char_done && armed && !full;
  assign ovr_char  = char_done && armed && full;
  assign len_hit   = take && xlen != '0 && 32'(xlen) <= 32'(CAP) && (char_cnt + 1'b1) == xlen;
  assign merged    = pword | (32'(shreg) << {bidx, 3'b000});
  assign char_push = take && (bidx == 2'd3 || len_hit);
  assign counting  = armed && !stale_flag && char_cnt != '0;
  assign stale_ev  = counting && state == S_IDLE && !char_done && os_tick &&
                     ctick == TW'(CHT - 1) && ({1'b0, ichar} + 9'd1) >= {1'b0, stale_to};
  assign flush_push = stale_ev && bidx != 2'd0 && !full;
  assign flush_ovr  = stale_ev && bidx != 2'd0 && full;
  assign push       = char_push || flush_push;
  assign push_data  = char_push ? merged : pword;

  always_ff @(posedge clk) begin
    if (push && !rst_rx) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level <= '0; wmark <= '0;
      pword <= '0; bidx <= '0; char_cnt <= '0; xlen <= '0; snap <= '0;
      stale_to <= 8'd15; ichar <= '0; ctick <= '0;
      armed <= 1'b0; stale_flag <= 1'b0; overrun <= 1'b0; ferr <= 1'b0;
    end else if (rst_rx) begin
      wptr <= '0; rptr <= '0; level <= '0;
      pword <= '0; bidx <= '0; char_cnt <= '0; snap <= '0;
      ichar <= '0; ctick <= '0; armed <= 1'b0;
      if (rst_err) begin overrun <= 1'b0; ferr <= 1'b0; end
      if (clr_stale) stale_flag <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      level <= level + LW'(push) - LW'(pop);

      if (take) begin
        char_cnt <= char_cnt + 1'b1;
        if (char_push) begin pword <= '0; bidx <= '0; end
        else begin pword <= merged; bidx <= bidx + 1'b1; end
      end
      if (stale_ev) begin
        pword <= '0; bidx <= '0;
        snap <= char_cnt; armed <= 1'b0; stale_flag <= 1'b1;
      end
      if (len_hit) begin
        snap <= char_cnt + 1'b1; armed <= 1'b0;
      end

      if (state != S_IDLE || char_done || wr_len) begin
        ctick <= '0; ichar <= '0;
      end else if (counting && os_tick) begin
        if (ctick == TW'(CHT - 1)) begin
          ctick <= '0; ichar <= ichar + 1'b1;
        end else ctick <= ctick + 1'b1;
      end

      if (wr_len) begin
        xlen <= reg_wdata[CW-1:0]; armed <= 1'b1; char_cnt <= '0;
      end
      if (reg_we && reg_addr == 3'd4) stale_to <= reg_wdata[7:0];
      if (reg_we && reg_addr == 3'd5) wmark <= reg_wdata[LW-1:0];
      if (clr_stale) stale_flag <= 1'b0;

      if (rst_err) begin overrun <= 1'b0; ferr <= 1'b0; end
      if (ovr_char || flush_ovr) overrun <= 1'b1;
      if (take && char_ferr) ferr <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = mem[rptr];
      3'd1:    reg_rdata = {26'b0, armed, stale_flag, ferr, overrun, full, level != '0};
      3'd3:    reg_rdata = 32'(xlen);
      3'd4:    reg_rdata = 32'(stale_to);
      3'd5:    reg_rdata = 32'(wmark);
      3'd6:    reg_rdata = 32'(snap);
      3'd7:    reg_rdata = 32'(level);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_rxlev = level > wmark;
  assign irq_stale = stale_flag;

  p_level_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(level) == LW'(DEPTH));
  p_stale_needs_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale_flag) |-> $past(armed));
  p_rx_reset_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rx |=> (level == '0 && !armed && bidx == 2'd0));
  p_unarmed_no_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !wr_len && !pop && !rst_rx) |=> $stable(level));
endmodule

// File: tb/uart_wordpack_rx_tb.sv
module uart_wordpack_rx_tb_top;
  localparam int OVS = 4;
  localparam int DEPTH = 4;
  localparam int BIT = 2 * OVS;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rx_in = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_rxlev, irq_stale;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  uart_wordpack_rx #(.OVS(OVS), .DEPTH(DEPTH), .CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_rxlev(irq_rxlev), .irq_stale(irq_stale));

  always #5 clk = ~clk;
  initial forever begin @(negedge clk); os_tick = ~os_tick; end

  localparam logic [67:0] TV [5] = '{
    {4'd1, 32'h000000A5, 32'h000000A5},
    {4'd2, 32'hFFFF3C5A, 32'h00003C5A},
    {4'd3, 32'hEE0081C3, 32'h000081C3},
    {4'd4, 32'h12345678, 32'h12345678},
    {4'd4, 32'h00FF0100, 32'h00FF0100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic popw(output logic [31:0] v);
    @(negedge clk); reg_addr = 3'd0; #1 v = reg_rdata; reg_re = 1'b1;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit good_stop);
    rx_in = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_in = b[i]; repeat (BIT) @(negedge clk); end
    rx_in = good_stop; repeat (BIT) @(negedge clk);
    rx_in = 1'b1; repeat (BIT) @(negedge clk);
  endtask

  task automatic wait_stale();
    for (int i = 0; i < 3000 && !irq_stale; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd1, v); chk("R12 reset status", v, 32'h0);
    rd(3'd7, v); chk("R12 reset level", v, 32'h0);
    rd(3'd4, v); chk("R3 reset stale timeout", v, 32'd15);
    rd(3'd6, v); chk("R4 reset snapshot", v, 32'h0);
    chk("R10 reset irqs", {irq_rxlev, irq_stale}, 32'h0);

    send(8'h55, 1);
    repeat (200) @(negedge clk);
    rd(3'd7, v); chk("R2 unarmed char ignored", v, 32'h0);
    chk("R2 no stale while unarmed", irq_stale, 1'b0);

    wr(3'd3, 32'd512);
    send(8'h11, 1);
    repeat (1150) @(negedge clk);
    chk("R3 stale not early", irq_stale, 1'b0);
    repeat (110) @(negedge clk);
    chk("R3 stale at 15 char times", irq_stale, 1'b1);
    rd(3'd1, v); chk("R3 stale status disarmed", v & 32'h30, 32'h10);
    rd(3'd6, v); chk("R4 snapshot one", v, 32'd1);
    popw(v); chk("R5 single char word", v, 32'h11);
    wr(3'd2, 32'h4);

    for (int t = 0; t < 5; t++) begin
      wr(3'd3, 32'd512);
      for (int i = 0; i < int'(TV[t][67:64]); i++) send(TV[t][32 + 8*i +: 8], 1);
      wait_stale();
      chk("R3 table stale", irq_stale, 1'b1);
      rd(3'd6, v); chk("R4 table snapshot", v, 32'(TV[t][67:64]));
      rd(3'd7, v); chk("R12 table level", v, 32'd1);
      popw(v); chk("R1 R5 table word", v, TV[t][31:0]);
      wr(3'd2, 32'h4);
    end

    wr(3'd4, 32'd3);
    wr(3'd3, 32'd512);
    for (int i = 1; i <= 6; i++) send(8'(i), 1);
    wait_stale();
    rd(3'd7, v); chk("R1 two words level", v, 32'd2);
    rd(3'd6, v); chk("R4 snapshot six", v, 32'd6);
    popw(v); chk("R1 first word order", v, 32'h04030201);
    popw(v); chk("R5 partial word zero fill", v, 32'h00000605);
    wr(3'd2, 32'h4);

    send(8'h77, 1);
    repeat (400) @(negedge clk);
    chk("R7 no stale without re-arm", irq_stale, 1'b0);
    rd(3'd7, v); chk("R7 char ignored before re-arm", v, 32'h0);

    wr(3'd3, 32'd3);
    send(8'hAA, 1); send(8'hBB, 1); send(8'hCC, 1);
    rd(3'd6, v); chk("R6 length snapshot", v, 32'd3);
    rd(3'd1, v); chk("R6 length end disarms, no stale", v & 32'h30, 32'h0);
    popw(v); chk("R6 length word", v, 32'h00CCBBAA);
    send(8'hDD, 1);
    rd(3'd7, v); chk("R6 no store after length end", v, 32'h0);

    wr(3'd3, 32'd512);
    wr(3'd5, 32'd1);
    for (int i = 0; i < 4; i++) send(8'h40 + 8'(i), 1);
    chk("R10 level equal watermark", irq_rxlev, 1'b0);
    for (int i = 0; i < 4; i++) send(8'h50 + 8'(i), 1);
    chk("R10 level above watermark", irq_rxlev, 1'b1);
    send(8'hEE, 1);
    wr(3'd2, 32'h1);
    rd(3'd7, v); chk("R11 reset empties FIFO", v, 32'h0);
    rd(3'd6, v); chk("R11 reset clears snapshot", v, 32'h0);
    rd(3'd1, v); chk("R11 reset disarms", v & 32'h20, 32'h0);
    wr(3'd5, 32'd0);
    wr(3'd3, 32'd512);
    send(8'h99, 1);
    wait_stale();
    popw(v); chk("R11 partial word discarded", v, 32'h99);
    wr(3'd2, 32'h4);

    wr(3'd3, 32'd512);
    for (int i = 0; i < 16; i++) send(8'h10 + 8'(i), 1);
    rd(3'd1, v); chk("R12 full flag", v & 32'h7, 32'h3);
    send(8'hF0, 1);
    rd(3'd1, v); chk("R8 overrun set", v & 32'h4, 32'h4);
    rd(3'd7, v); chk("R8 level stays at depth", v, 32'd4);
    wr(3'd2, 32'h2);
    rd(3'd1, v); chk("R8 overrun cleared", v & 32'h4, 32'h0);
    popw(v); chk("R12 pop head word", v, 32'h13121110);
    rd(3'd7, v); chk("R12 level after pop", v, 32'd3);
    wr(3'd2, 32'h5);

    wr(3'd3, 32'd512);
    send(8'h3C, 0);
    repeat (20) @(negedge clk);
    rd(3'd1, v); chk("R9 frame error set", v & 32'h8, 32'h8);
    wait_stale();
    popw(v); chk("R9 char still stored", v, 32'h3C);
    wr(3'd2, 32'h6);
    rd(3'd1, v); chk("R9 frame error cleared", v & 32'h8, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule